// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a bank of on-chip configuration bytes from a small serial EEPROM. It drives chip select, serial clock and data-in to the memory and reads each byte back over the data-out line. While it reads, it adds every byte into an 8-bit running sum. When the load ends, it raises a valid flag only if the memory answered and the sum came out right. While a load runs, a busy output tells the host bus interface to answer every access with a retry.

A load starts by itself after hard reset, but only if the detect pin read 1 on the last reset cycle. The host can also start a load at any time by setting a command bit, and the detect flag does not gate that load. If no memory answers, the configuration bytes go back to their default values. The three EEPROM pins are shared with other functions. When no load is running, the host can drive them directly from software bits. Otherwise they carry two LED signals, with chip select held low.

Top module: `cfg_rom_loader`

## Requirements
- R1: On the first clock after hard reset ends, `busy` rises if `eeDetect` was 1 on the last reset cycle. If it was 0, `busy` stays 0, `cfgValid` stays 0 and `regImage` keeps its defaults.
- R2: `eeDetected` holds the value `eeDetect` had on the last hard-reset cycle. Later changes on the pin and later loads leave it unchanged until the next hard reset.
- R3: A host write with `hostWr`=1 and `hostWrData`=1, made while `stopOrSuspend`=1 and no load runs, starts a load on the next clock whatever `eeDetected` holds. A write made while `stopOrSuspend`=0 is ignored: `loadCmd` and `busy` stay 0.
- R4: Each byte is one transaction with chip select high. The loader sends read opcode 0x03 and then an 8-bit address, MSB first. Data-in changes while the serial clock is low and is taken at its rising edge. Next comes one dummy bit, which a present memory drives to 0, then 8 data bits, MSB first. The memory changes data-out after a falling clock edge and the loader samples it at the next rising edge. Addresses run 0 to NUM_BYTES-1 in order. The clock stays HALF_DIV cycles low and HALF_DIV cycles high. Chip select stays low for 2*HALF_DIV cycles between bytes. A full load keeps `busy` high for NUM_BYTES*52*HALF_DIV+1 cycles.
- R5: The byte read from address i appears in `regImage` bits [8i+7:8i].
- R6: At the end of a load, `cfgValid` is 1 only if the 8-bit sum of all NUM_BYTES bytes equals 0xFF. If the sum is wrong, `cfgValid` is 0 and `regImage` still holds the bytes that were read.
- R7: If data-out reads 1 at the dummy bit, the load stops. `regImage` returns to its defaults, where byte i is the low 8 bits of 29*i+7. `cfgValid` is 0 and `loadCmd` clears.
- R8: `loadCmd` is 0 after hard reset and during a reset-triggered load. It is 1 during a host-started load, and it clears on the same clock edge where `busy` falls.
- R9: `busy` stays high for the whole load, and `cfgValid` reads 0 while `busy` is high.
- R10: While no load runs and `portEn`=0, `eeCs`=0, `eeSk` follows `ledA` and `eeDi` follows `ledB`.
- R11: While no load runs and `portEn`=1, `eeCs`, `eeSk` and `eeDi` follow `swCs`, `swSk` and `swDi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Hard reset, active low, synchronous |
| eeDetect | input | 1 | EEPROM-present detect pin, sampled during reset |
| hostWr | input | 1 | Host write strobe for the command bit |
| hostWrData | input | 1 | Value written to the command bit |
| stopOrSuspend | input | 1 | Stop or suspend state; host writes are accepted only while it is 1 |
| portEn | input | 1 | Software pin-override enable |
| swCs | input | 1 | Software chip-select value |
| swSk | input | 1 | Software serial-clock value |
| swDi | input | 1 | Software data-in value |
| ledA | input | 1 | LED signal sent to the clock pin when it is free |
| ledB | input | 1 | LED signal sent to the data-in pin when it is free |
| eeDo | input | 1 | EEPROM data-out, pulled high when no memory is fitted |
| eeCs | output | 1 | EEPROM chip select |
| eeSk | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | EEPROM data-in |
| busy | output | 1 | Load in progress; the bus interface answers with retry |
| loadCmd | output | 1 | Host read-command bit, clears by itself |
| eeDetected | output | 1 | Read-only detect flag |
| cfgValid | output | 1 | Last load completed with a correct sum |
| regImage | output | NUM_BYTES*8 | Configuration bytes, byte i at bits [8i+7:8i] |

## Verification
On the cycle a load ends, three things change together: `busy` falls, `loadCmd` clears, and `cfgValid` takes its final value. The pins also go back to the LED or software sources on that cycle. The bench steps to the first falling clock edge where `busy` is low. There it judges `loadCmd`, `cfgValid`, `regImage` and the busy-cycle count together, against values worked out from the image it loaded into its EEPROM model. Loads with good sums, corrupted sums and a missing memory are run this way, both after reset and after a host command. A host write made while stop/suspend is low is also shown to have no effect at that boundary.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_GAP,
    ST_DONE
  } ldState_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic startLoad;   // reset counters and sum, queue address 0
    logic nextByte;    // advance to the next address
    logic shiftCmd;    // move the next command bit onto data-in
    logic sampleBit;   // shift data-out into the byte register
    logic commitByte;  // write the byte into the image and add it to the sum
    logic restoreDef;  // memory absent: reload defaults
    logic finish;      // load over
    logic finishGood;  // memory answered for the whole load
  } ldStrobe_t;

  function automatic logic [7:0] defaultByte(input int unsigned idx);
    int unsigned v;
    v = idx * 29 + 7;
    return v[7:0];
  endfunction

endpackage

// File: rtl/cfgld_ctrl.sv
module cfgld_ctrl
  import cfgld_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      detFlag,
  input  logic      hostWr,
  input  logic      hostWrData,
  input  logic      stopOrSuspend,
  input  logic      eeDo,
  input  logic      lastByte,
  output ldStrobe_t strb,
  output logic      seqCs,
  output logic      seqSk,
  output logic      busy,
  output logic      cmdBit
);

  localparam int CMD_BITS = 8 + ADDR_W;
  localparam int LAST_BIT = CMD_BITS + 8;
  localparam int BIT_W    = $clog2(LAST_BIT + 1);
  localparam int DIV_W    = $clog2(2 * HALF_DIV + 1);

  ldState_t         state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             csReg, skReg, abortReg, cmdReg;

  logic hostStart, halfDone, gapDone, atDummy, inData, atLast;

  assign hostStart = hostWr && hostWrData && stopOrSuspend && (state == ST_IDLE);
  assign halfDone  = divCnt == DIV_W'(HALF_DIV - 1);
  assign gapDone   = divCnt == DIV_W'(2 * HALF_DIV - 1);
  assign atDummy   = bitIdx == BIT_W'(CMD_BITS);
  assign inData    = bitIdx > BIT_W'(CMD_BITS);
  assign atLast    = bitIdx == BIT_W'(LAST_BIT);

  always_comb begin
    strb = '0;
    unique case (state)
      ST_BOOT: strb.startLoad = detFlag;
      ST_IDLE: strb.startLoad = hostStart;
      ST_LO: if (halfDone) begin
        strb.sampleBit  = inData;
        strb.restoreDef = atDummy && eeDo;
      end
      ST_HI: if (halfDone) begin
        strb.commitByte = atLast;
        strb.shiftCmd   = !atLast;
      end
      ST_GAP: if (gapDone) strb.nextByte = !lastByte;
      ST_DONE: begin
        strb.finish     = 1'b1;
        strb.finishGood = !abortReg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_BOOT;
      divCnt   <= '0;
      bitIdx   <= '0;
      csReg    <= 1'b0;
      skReg    <= 1'b0;
      abortReg <= 1'b0;
      cmdReg   <= 1'b0;
    end else begin
      divCnt <= divCnt + 1'b1;
      unique case (state)
        ST_BOOT: begin
          divCnt <= '0;
          if (detFlag) begin
            state    <= ST_LO;
            csReg    <= 1'b1;
            bitIdx   <= '0;
            abortReg <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          divCnt <= '0;
          if (hostStart) begin
            state    <= ST_LO;
            csReg    <= 1'b1;
            bitIdx   <= '0;
            abortReg <= 1'b0;
            cmdReg   <= 1'b1;
          end
        end
        ST_LO: if (halfDone) begin
          divCnt <= '0;
          if (atDummy && eeDo) begin
            abortReg <= 1'b1;
            csReg    <= 1'b0;
            state    <= ST_DONE;
          end else begin
            skReg <= 1'b1;
            state <= ST_HI;
          end
        end
        ST_HI: if (halfDone) begin
          divCnt <= '0;
          skReg  <= 1'b0;
          if (atLast) begin
            csReg <= 1'b0;
            state <= ST_GAP;
          end else begin
            bitIdx <= bitIdx + 1'b1;
            state  <= ST_LO;
          end
        end
        ST_GAP: if (gapDone) begin
          divCnt <= '0;
          if (lastByte) begin
            state <= ST_DONE;
          end else begin
            state  <= ST_LO;
            csReg  <= 1'b1;
            bitIdx <= '0;
          end
        end
        ST_DONE: begin
          divCnt <= '0;
          cmdReg <= 1'b0;
          state  <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign seqCs  = csReg;
  assign seqSk  = skReg;
  assign cmdBit = cmdReg;
  assign busy   = (state == ST_LO) || (state == ST_HI) ||
                  (state == ST_GAP) || (state == ST_DONE);

endmodule

// File: rtl/cfgld_datapath.sv
module cfgld_datapath
  import cfgld_pkg::*;
#(
  parameter int         NUM_BYTES = 68,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] READ_OP   = 8'h03
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   eeDetect,
  input  logic                   eeDo,
  input  ldStrobe_t              strb,
  output logic                   detFlag,
  output logic                   lastByte,
  output logic                   seqDi,
  output logic                   cfgValid,
  output logic [NUM_BYTES*8-1:0] regImage
);

  localparam int CMD_BITS = 8 + ADDR_W;
  localparam int IDX_W    = $clog2(NUM_BYTES);

  logic [IDX_W-1:0]    byteIdx;
  logic [CMD_BITS-1:0] cmdSr;
  logic [7:0]          dataSr;
  logic [7:0]          sumAcc;

  // detect pin is followed while reset is held and frozen once it ends
  always_ff @(posedge clk) begin
    if (!rstN) detFlag <= eeDetect;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx  <= '0;
      cmdSr    <= '0;
      dataSr   <= '0;
      sumAcc   <= '0;
      cfgValid <= 1'b0;
    end else begin
      if (strb.startLoad) begin
        byteIdx  <= '0;
        cmdSr    <= {READ_OP, ADDR_W'(0)};
        sumAcc   <= '0;
        cfgValid <= 1'b0;
      end else if (strb.nextByte) begin
        byteIdx <= byteIdx + 1'b1;
        cmdSr   <= {READ_OP, ADDR_W'(byteIdx + 1'b1)};
      end else if (strb.shiftCmd) begin
        cmdSr <= {cmdSr[CMD_BITS-2:0], 1'b0};
      end
      if (strb.sampleBit)  dataSr <= {dataSr[6:0], eeDo};
      if (strb.commitByte) sumAcc <= sumAcc + dataSr;
      if (strb.finish)     cfgValid <= strb.finishGood && (sumAcc == 8'hFF);
    end
  end

  assign lastByte = byteIdx == IDX_W'(NUM_BYTES - 1);
  assign seqDi    = cmdSr[CMD_BITS-1];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_img
    logic [7:0] byteQ;
    always_ff @(posedge clk) begin
      if (!rstN || strb.restoreDef)
        byteQ <= defaultByte(g);
      else if (strb.commitByte && byteIdx == IDX_W'(g))
        byteQ <= dataSr;
    end
    assign regImage[8*g +: 8] = byteQ;
  end

endmodule

// File: rtl/cfgld_pinmux.sv
module cfgld_pinmux (
  input  logic busy,
  input  logic seqCs,
  input  logic seqSk,
  input  logic seqDi,
  input  logic portEn,
  input  logic swCs,
  input  logic swSk,
  input  logic swDi,
  input  logic ledA,
  input  logic ledB,
  output logic eeCs,
  output logic eeSk,
  output logic eeDi
);

  always_comb begin
    if (busy) begin
      eeCs = seqCs;
      eeSk = seqSk;
      eeDi = seqDi;
    end else if (portEn) begin
      eeCs = swCs;
      eeSk = swSk;
      eeDi = swDi;
    end else begin
      eeCs = 1'b0;
      eeSk = ledA;
      eeDi = ledB;
    end
  end

endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfgld_pkg::*;
#(
  parameter int         NUM_BYTES = 68,
  parameter int         ADDR_W    = 8,
  parameter logic [7:0] READ_OP   = 8'h03,
  parameter int         HALF_DIV  = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   eeDetect,
  input  logic                   hostWr,
  input  logic                   hostWrData,
  input  logic                   stopOrSuspend,
  input  logic                   portEn,
  input  logic                   swCs,
  input  logic                   swSk,
  input  logic                   swDi,
  input  logic                   ledA,
  input  logic                   ledB,
  input  logic                   eeDo,
  output logic                   eeCs,
  output logic                   eeSk,
  output logic                   eeDi,
  output logic                   busy,
  output logic                   loadCmd,
  output logic                   eeDetected,
  output logic                   cfgValid,
  output logic [NUM_BYTES*8-1:0] regImage
);

  ldStrobe_t strb;
  logic      seqCs, seqSk, seqDi, lastByte;

  cfgld_ctrl #(.ADDR_W(ADDR_W), .HALF_DIV(HALF_DIV)) i_ctrl (
    .clk(clk), .rstN(rstN), .detFlag(eeDetected), .hostWr(hostWr),
    .hostWrData(hostWrData), .stopOrSuspend(stopOrSuspend), .eeDo(eeDo),
    .lastByte(lastByte), .strb(strb), .seqCs(seqCs), .seqSk(seqSk),
    .busy(busy), .cmdBit(loadCmd)
  );

  cfgld_datapath #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W), .READ_OP(READ_OP)) i_dp (
    .clk(clk), .rstN(rstN), .eeDetect(eeDetect), .eeDo(eeDo), .strb(strb),
    .detFlag(eeDetected), .lastByte(lastByte), .seqDi(seqDi),
    .cfgValid(cfgValid), .regImage(regImage)
  );

  cfgld_pinmux i_mux (
    .busy(busy), .seqCs(seqCs), .seqSk(seqSk), .seqDi(seqDi), .portEn(portEn),
    .swCs(swCs), .swSk(swSk), .swDi(swDi), .ledA(ledA), .ledB(ledB),
    .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi)
  );

endmodule

// File: rtl/cfg_rom_loader_chk.sv
module cfg_rom_loader_chk (
  input logic clk,
  input logic rstN,
  input logic hostWr,
  input logic hostWrData,
  input logic stopOrSuspend,
  input logic portEn,
  input logic swCs,
  input logic swSk,
  input logic swDi,
  input logic ledA,
  input logic ledB,
  input logic eeCs,
  input logic eeSk,
  input logic eeDi,
  input logic busy,
  input logic loadCmd,
  input logic eeDetected,
  input logic cfgValid
);

  // set once a full cycle has passed out of reset
  logic armed;
  always_ff @(posedge clk) armed <= rstN;

  AST_DETECT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> $stable(eeDetected)); // R2

  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(loadCmd) |-> $past(hostWr && hostWrData && stopOrSuspend)); // R3

  AST_CLOCK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !eeCs) |-> !eeSk); // R4

  AST_CMD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !loadCmd); // R8

  AST_CMD_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    loadCmd |-> busy); // R8

  AST_NO_VALID_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !cfgValid); // R9

  AST_LED_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !portEn) |-> (!eeCs && eeSk == ledA && eeDi == ledB)); // R10

  AST_SW_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && portEn) |-> (eeCs == swCs && eeSk == swSk && eeDi == swDi)); // R11

endmodule

bind cfg_rom_loader cfg_rom_loader_chk i_chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostWrData(hostWrData),
  .stopOrSuspend(stopOrSuspend), .portEn(portEn), .swCs(swCs), .swSk(swSk),
  .swDi(swDi), .ledA(ledA), .ledB(ledB), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
  .busy(busy), .loadCmd(loadCmd), .eeDetected(eeDetected), .cfgValid(cfgValid)
);

// File: tb/test_cfg_rom_loader.sv
module test_cfg_rom_loader;
  localparam int NB   = 68;
  localparam int HALF = 2;
  localparam int IW   = NB * 8;
  localparam int LOAD_CYCLES = NB * 52 * HALF + 1;
  typedef logic [IW-1:0] wide_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, eeDetect = 1'b1, hostWr = 1'b0, hostWrData = 1'b0;
  logic stopOrSuspend = 1'b0, portEn = 1'b0, swCs = 1'b0, swSk = 1'b0, swDi = 1'b0;
  logic ledA = 1'b0, ledB = 1'b0, eeDo = 1'b1;
  logic eeCs, eeSk, eeDi, busy, loadCmd, eeDetected, cfgValid;
  wide_t regImage;

  cfg_rom_loader #(.NUM_BYTES(NB), .ADDR_W(8), .READ_OP(8'h03), .HALF_DIV(HALF)) i_cfg_rom_loader (
    .clk(clk), .rstN(rstN), .eeDetect(eeDetect), .hostWr(hostWr), .hostWrData(hostWrData),
    .stopOrSuspend(stopOrSuspend), .portEn(portEn), .swCs(swCs), .swSk(swSk), .swDi(swDi),
    .ledA(ledA), .ledB(ledB), .eeDo(eeDo), .eeCs(eeCs), .eeSk(eeSk), .eeDi(eeDi),
    .busy(busy), .loadCmd(loadCmd), .eeDetected(eeDetected), .cfgValid(cfgValid),
    .regImage(regImage)
  );

  int errors = 0, checks = 0;

  // ---------------- EEPROM model ----------------
  logic [7:0]  rom [NB];
  logic        romPresent = 1'b1;
  int          edgeCnt = 0, lastAddr = -1, protoErr = 0;
  logic [15:0] cmdSh = '0;
  logic        prevCs = 1'b0, prevSk = 1'b0;
  logic [7:0]  curByte = '0;

  always @(eeCs or eeSk) begin
    if (eeCs && !prevCs) edgeCnt = 0;
    if (!eeCs && prevCs) eeDo = 1'b1;
    if (eeCs && eeSk && !prevSk) begin
      if (edgeCnt < 16) cmdSh = {cmdSh[14:0], eeDi};
      edgeCnt++;
      if (edgeCnt == 16) begin
        if (cmdSh[15:8] != 8'h03) protoErr++;
        if (cmdSh[7:0] == 8'd0) lastAddr = 0;
        else if (int'(cmdSh[7:0]) == lastAddr + 1) lastAddr = lastAddr + 1;
        else protoErr++;
        curByte = (int'(cmdSh[7:0]) < NB) ? rom[cmdSh[7:0]] : 8'h00;
      end
    end
    if (eeCs && !eeSk && prevSk) begin
      if (!romPresent) eeDo = 1'b1;
      else if (edgeCnt == 16) eeDo = 1'b0;
      else if (edgeCnt >= 17 && edgeCnt <= 24) eeDo = curByte[7 - (edgeCnt - 17)];
    end
    prevCs = eeCs;
    prevSk = eeSk;
  end

  // ---------------- expected-value functions ----------------
  function automatic logic [7:0] defByte(input int i);
    int v;
    v = (i * 29 + 7) % 256;
    return v[7:0];
  endfunction

  function automatic wide_t defImage();
    wide_t v;
    for (int i = 0; i < NB; i++) v[8*i +: 8] = defByte(i);
    return v;
  endfunction

  function automatic wide_t romImage();
    wide_t v;
    for (int i = 0; i < NB; i++) v[8*i +: 8] = rom[i];
    return v;
  endfunction

  function automatic logic [2:0] pinExp(input logic pe, sc, ss, sd, la, lb);
    return pe ? {sc, ss, sd} : {1'b0, la, lb};
  endfunction

  task automatic chk(input string tag, input wide_t act, input wide_t exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic makeRom(input bit good);
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < NB - 1; i++) begin
      rom[i] = 8'($urandom);
      s = s + rom[i];
    end
    rom[NB-1] = 8'hFF - s;
    if (!good) rom[NB-1] = rom[NB-1] ^ 8'($urandom_range(1, 255));
  endtask

  task automatic doReset(input logic det);
    @(negedge clk);
    rstN = 1'b0;
    eeDetect = det;
    repeat (3) @(negedge clk);
    chk("R8 cmd bit in reset", wide_t'(loadCmd), wide_t'(0));
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic hostWrite(input logic stop);
    @(negedge clk);
    hostWr = 1'b1;
    hostWrData = 1'b1;
    stopOrSuspend = stop;
    @(negedge clk);
    hostWr = 1'b0;
    hostWrData = 1'b0;
    stopOrSuspend = 1'b0;
  endtask

  task automatic runLoad(output int cnt);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == 50) chk("R9 valid low while busy", wide_t'(cfgValid), wide_t'(0));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R9: actual=busy stuck expected=load finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt;
    logic [2:0] pe;
    bit good;
    void'($urandom(32'd7781));

    // reset-triggered load with a good image
    makeRom(1'b1);
    romPresent = 1'b1;
    doReset(1'b1);
    chk("R1 auto load starts", wide_t'(busy), wide_t'(1));
    chk("R8 cmd bit clear in auto load", wide_t'(loadCmd), wide_t'(0));
    runLoad(cnt);
    chk("R4 busy length", wide_t'(cnt), wide_t'(LOAD_CYCLES));
    chk("R4 opcode and address order", wide_t'(protoErr), wide_t'(0));
    chk("R4 last address", wide_t'(lastAddr), wide_t'(NB - 1));
    chk("R6 valid after good sum", wide_t'(cfgValid), wide_t'(1));
    chk("R5 image placement", regImage, romImage());
    chk("R8 cmd bit after load", wide_t'(loadCmd), wide_t'(0));

    // detect flag is frozen
    chk("R2 detect sampled", wide_t'(eeDetected), wide_t'(1));
    eeDetect = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 detect held", wide_t'(eeDetected), wide_t'(1));

    // pin muxing while idle, random patterns
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      portEn = (k < 2) ? k[0] : 1'($urandom);
      swCs = 1'($urandom); swSk = 1'($urandom); swDi = 1'($urandom);
      ledA = 1'($urandom); ledB = 1'($urandom);
      #1;
      pe = pinExp(portEn, swCs, swSk, swDi, ledA, ledB);
      if (portEn) chk("R11 software pins", wide_t'({eeCs, eeSk, eeDi}), wide_t'(pe));
      else        chk("R10 LED fallback", wide_t'({eeCs, eeSk, eeDi}), wide_t'(pe));
    end
    @(negedge clk);
    portEn = 1'b0; swCs = 1'b0; swSk = 1'b0; swDi = 1'b0;

    // write without stop/suspend is ignored
    hostWrite(1'b0);
    repeat (3) @(negedge clk);
    chk("R3 write ignored busy", wide_t'(busy), wide_t'(0));
    chk("R3 write ignored cmd", wide_t'(loadCmd), wide_t'(0));

    // host load with a corrupted sum
    makeRom(1'b0);
    hostWrite(1'b1);
    chk("R3 host start busy", wide_t'(busy), wide_t'(1));
    chk("R8 cmd bit set", wide_t'(loadCmd), wide_t'(1));
    runLoad(cnt);
    chk("R4 busy length host", wide_t'(cnt), wide_t'(LOAD_CYCLES));
    chk("R6 valid low on bad sum", wide_t'(cfgValid), wide_t'(0));
    chk("R6 image kept on bad sum", regImage, romImage());
    chk("R8 cmd bit self clears", wide_t'(loadCmd), wide_t'(0));

    // host load with the memory absent
    romPresent = 1'b0;
    hostWrite(1'b1);
    chk("R3 absent load starts", wide_t'(busy), wide_t'(1));
    runLoad(cnt);
    chk("R7 defaults restored", regImage, defImage());
    chk("R7 valid low when absent", wide_t'(cfgValid), wide_t'(0));
    chk("R7 cmd bit clears", wide_t'(loadCmd), wide_t'(0));

    // reset with detect low: no auto load, host load still runs
    romPresent = 1'b1;
    makeRom(1'b1);
    doReset(1'b0);
    repeat (4) @(negedge clk);
    chk("R1 no auto load", wide_t'(busy), wide_t'(0));
    chk("R1 valid low", wide_t'(cfgValid), wide_t'(0));
    chk("R1 defaults kept", regImage, defImage());
    chk("R2 detect low", wide_t'(eeDetected), wide_t'(0));
    eeDetect = 1'b1;
    hostWrite(1'b1);
    chk("R3 host load ignores detect", wide_t'(busy), wide_t'(1));
    runLoad(cnt);
    chk("R6 valid after host load", wide_t'(cfgValid), wide_t'(1));
    chk("R5 image after host load", regImage, romImage());
    chk("R2 detect unchanged by load", wide_t'(eeDetected), wide_t'(0));

    // random good/bad loads
    for (int k = 0; k < 3; k++) begin
      good = 1'($urandom);
      makeRom(good);
      hostWrite(1'b1);
      runLoad(cnt);
      chk("R6 random valid", wide_t'(cfgValid), wide_t'(good));
      chk("R5 random image", regImage, romImage());
      chk("R4 random protocol", wide_t'(protoErr), wide_t'(0));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule